// File: doc/BRIEF.md
# Linked Descriptor Chain Sequencer

This block walks a chain of transfer descriptors kept in a small on-block table. Each descriptor holds the transfer geometry (source and destination addresses, three counts, four strides), a reload value for the second-level count, a link index naming the descriptor that follows, a wait identifier, and a final bit. Software fills the table through a one-cycle write port, then pulses start with the index of the first descriptor. The sequencer copies that descriptor into an active register set and issues it to an external address engine with a one-cycle go pulse.

When the engine reports that the transfer is finished, the sequencer raises the completion flag the descriptor asked for, if any. It then either loads the descriptor named by the link and issues it, or ends the chain. A chain ends at a null link (all ones), at a link that points past the table, or at a descriptor whose final bit is set. Two descriptors that link to each other form an endless ping-pong loop that needs no help from software. Flag 0 and the all-done output mark the end of the whole chain. All flags stay set until the next accepted start.

Top module: `chain_seq`

## Requirements
- R1: After reset, busy, eng_go, all_done and every bit of wait_flags are 0.
- R2: A cycle with wr_en high stores wr_desc whole into slot wr_slot. The descriptor bit layout is: source address [216:185], destination address [184:153], three counts [152:105], four strides [104:41], count reload [40:25], link index [24:9], wait id [8:1] (signed), final bit [0].
- R3: A start accepted with a valid start_link makes busy 1 and eng_go 1 in the next cycle. In that cycle act_slot equals the start index and act_desc equals the stored descriptor bit for bit, the reload field included.
- R4: eng_go is high for exactly one cycle per loaded descriptor, and only while busy.
- R5: When eng_done is high while busy and the chain does not end, the descriptor named by the link of the active one is loaded, with eng_go high in the next cycle. Two descriptors that link to each other alternate with no limit.
- R6: A link of 0xFFFF, or one not below the slot count (16), is null. A start with a null start_link ends at once: all_done and flag 0 are set in the next cycle, busy stays 0, and eng_go stays 0.
- R7: A descriptor whose final bit is set ends the chain when it completes, even if its link is valid. In the cycle after the last eng_done, busy is 0, all_done is 1 and wait_flags[0] is 1.
- R8: On completion, a wait id from 1 to WAITS-1 (8 by default) sets that bit of wait_flags. Wait id -1 (0xFF), wait id 0, and wait ids of WAITS or more set no flag; only the chain end sets bit 0.
- R9: wait_flags and all_done keep their values while idle, and an accepted start clears them.
- R10: A start while busy is ignored. The active slot, the active descriptor and the chain progress are unchanged.
- R11: Rewriting a slot while it is active does not alter act_desc. The new contents appear the next time that slot is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_slot | input | 4 | Slot index for the write |
| wr_desc | input | 217 | Descriptor to write |
| start | input | 1 | Start request (taken only when idle) |
| start_link | input | 16 | Index of the first descriptor |
| eng_go | output | 1 | One-cycle issue pulse to the address engine |
| act_slot | output | 4 | Slot index of the active descriptor |
| act_desc | output | 217 | Active descriptor copy |
| eng_done | input | 1 | Engine reports completion of the active transfer |
| busy | output | 1 | Chain in progress |
| wait_flags | output | 8 | Sticky per-wait-id completion flags; bit 0 is chain end |
| all_done | output | 1 | Sticky whole-chain completion |

## Verification
Every result is one register away from its cause. eng_go, act_slot and act_desc change at the clock edge that accepts start or eng_done, and wait_flags, all_done and busy change at the edge that takes the last eng_done. The bench drives inputs on the falling edge and samples on the falling edge after the rising edge that consumes them, so each check lands in the first cycle its result is due. The cycle after each go is sampled as well, to confirm the pulse has dropped.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
    parameter int ADDR_W = 32;
    parameter int CNT_W  = 16;
    parameter int IDX_W  = 16;
    parameter int LINK_W = 16;
    parameter int WID_W  = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  acnt;
        logic [CNT_W-1:0]  bcnt;
        logic [CNT_W-1:0]  ccnt;
        logic [IDX_W-1:0]  sbidx;
        logic [IDX_W-1:0]  dbidx;
        logic [IDX_W-1:0]  scidx;
        logic [IDX_W-1:0]  dcidx;
        logic [CNT_W-1:0]  bcnt_rld;
        logic [LINK_W-1:0] link;
        logic [WID_W-1:0]  wait_id;
        logic              last;
    } xfer_desc_t;

    localparam int DESC_W = $bits(xfer_desc_t);
    localparam logic [LINK_W-1:0] LINK_NULL = '1;
endpackage

// File: rtl/xcs_desc_store.sv
module xcs_desc_store
    import xcs_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  xfer_desc_t        wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output xfer_desc_t        rd_data
);
    // Empty slots read back as terminating descriptors.
    localparam xfer_desc_t EMPTY_DESC = '{link: LINK_NULL, wait_id: '1, default: '0};

    xfer_desc_t mem_q [SLOTS];
    xfer_desc_t mem_d [SLOTS];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && (int'(wr_slot) == i)) begin
                mem_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (!rst_n) mem_q[i] <= EMPTY_DESC;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_slot];
endmodule

// File: rtl/xcs_link_check.sv
module xcs_link_check
    import xcs_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic [LINK_W-1:0] link,
    output logic              ok,
    output logic [SLOT_W-1:0] slot
);
    assign ok   = (link != LINK_NULL) && (int'(link) < SLOTS);
    assign slot = link[SLOT_W-1:0];
endmodule

// File: rtl/xcs_wait_decode.sv
module xcs_wait_decode
    import xcs_pkg::*;
#(
    parameter int WAITS = 8
) (
    input  logic [WID_W-1:0] wait_id,
    input  logic             chain_end,
    output logic [WAITS-1:0] set_mask
);
    // Negative ids have the top bit set and so never match a bit below WAITS.
    for (genvar g = 0; g < WAITS; g++) begin : g_bit
        if (g == 0) begin : g_end
            assign set_mask[g] = chain_end;
        end else begin : g_id
            assign set_mask[g] = (wait_id == WID_W'(g));
        end
    end
endmodule

// File: rtl/chain_seq.sv
module chain_seq
    import xcs_pkg::*;
#(
    parameter  int SLOTS  = 16,
    parameter  int WAITS  = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DESC_W-1:0] wr_desc,
    input  logic              start,
    input  logic [LINK_W-1:0] start_link,
    output logic              eng_go,
    output logic [SLOT_W-1:0] act_slot,
    output logic [DESC_W-1:0] act_desc,
    input  logic              eng_done,
    output logic              busy,
    output logic [WAITS-1:0]  wait_flags,
    output logic              all_done
);
    typedef struct packed {
        logic              busy;
        logic              go;
        logic              done;
        logic [SLOT_W-1:0] slot;
        logic [WAITS-1:0]  flags;
        xfer_desc_t        act;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic              start_ok, next_ok, chain_end, accept_start;
    logic [SLOT_W-1:0] start_slot, next_slot, rd_slot;
    logic [WAITS-1:0]  set_mask;
    xfer_desc_t        rd_data;

    xcs_desc_store #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (xfer_desc_t'(wr_desc)),
        .rd_slot (rd_slot),
        .rd_data (rd_data)
    );

    xcs_link_check #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_start_chk (
        .link (start_link),
        .ok   (start_ok),
        .slot (start_slot)
    );

    xcs_link_check #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_next_chk (
        .link (st_q.act.link),
        .ok   (next_ok),
        .slot (next_slot)
    );

    xcs_wait_decode #(.WAITS(WAITS)) u_wait (
        .wait_id   (st_q.act.wait_id),
        .chain_end (chain_end),
        .set_mask  (set_mask)
    );

    assign accept_start = start && !st_q.busy;
    assign chain_end    = st_q.act.last || !next_ok;
    assign rd_slot      = accept_start ? start_slot : next_slot;

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        if (accept_start) begin
            st_d.flags = '0;
            st_d.done  = 1'b0;
            if (start_ok) begin
                st_d.busy = 1'b1;
                st_d.go   = 1'b1;
                st_d.act  = rd_data;
                st_d.slot = start_slot;
            end else begin
                st_d.done  = 1'b1;
                st_d.flags = WAITS'(1);
            end
        end else if (st_q.busy && eng_done) begin
            st_d.flags = st_q.flags | set_mask;
            if (chain_end) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.go   = 1'b1;
                st_d.act  = rd_data;
                st_d.slot = next_slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eng_go     = st_q.go;
    assign act_slot   = st_q.slot;
    assign act_desc   = st_q.act;
    assign busy       = st_q.busy;
    assign wait_flags = st_q.flags;
    assign all_done   = st_q.done;
endmodule

// File: rtl/xcs_chk.sv
module xcs_chk
    import xcs_pkg::*;
#(
    parameter int WAITS  = 8,
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              eng_go,
    input logic              eng_done,
    input logic              busy,
    input logic              all_done,
    input logic [WAITS-1:0]  wait_flags,
    input logic [SLOT_W-1:0] act_slot,
    input logic [DESC_W-1:0] act_desc
);
    AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> busy);                                               // R4
    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go && !eng_done |=> !eng_go);                               // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> !busy);                                            // R7
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(wait_flags) && $stable(all_done));  // R9
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> (wait_flags[WAITS-1:1] == '0));              // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !eng_done |=> $stable(act_slot) && $stable(act_desc)); // R10
endmodule

bind chain_seq xcs_chk #(.WAITS(WAITS), .SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .eng_go     (eng_go),
    .eng_done   (eng_done),
    .busy       (busy),
    .all_done   (all_done),
    .wait_flags (wait_flags),
    .act_slot   (act_slot),
    .act_desc   (act_desc)
);

// File: tb/sim_chain_seq.sv
`timescale 1ns/1ps
module sim_chain_seq;
    localparam int DW = 217;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_slot = '0;
    logic [DW-1:0] wr_desc = '0;
    logic          start = 1'b0;
    logic [15:0]   start_link = '0;
    logic          eng_go;
    logic [3:0]    act_slot;
    logic [DW-1:0] act_desc;
    logic          eng_done = 1'b0;
    logic          busy;
    logic [7:0]    wait_flags;
    logic          all_done;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    chain_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_desc(wr_desc),
        .start(start), .start_link(start_link), .eng_go(eng_go), .act_slot(act_slot),
        .act_desc(act_desc), .eng_done(eng_done), .busy(busy), .wait_flags(wait_flags),
        .all_done(all_done)
    );

    // Rows: start link, transfer count, three expected slots, expected final flags.
    localparam logic [39:0] ROWS [6] = '{
        {16'd0,     4'd3, 4'd0, 4'd1, 4'd2, 8'h29},
        {16'd3,     4'd1, 4'd3, 4'd0, 4'd0, 8'h05},
        {16'd4,     4'd2, 4'd4, 4'd5, 4'd0, 8'h81},
        {16'd6,     4'd2, 4'd6, 4'd7, 4'd0, 8'h03},
        {16'hFFFF,  4'd0, 4'd0, 4'd0, 4'd0, 8'h01},
        {16'd16,    4'd0, 4'd0, 4'd0, 4'd0, 8'h01}
    };

    function automatic logic [DW-1:0] mk(input logic [31:0] src, input logic [15:0] rld,
                                         input logic [15:0] link, input logic [7:0] wid,
                                         input logic fin);
        return {src, 32'hD000_0000 + src, 16'd4, 16'd2, 16'd1,
                16'd0, 16'd0, 16'd0, 16'd0, rld, link, wid, fin};
    endfunction

    function automatic logic [31:0] src_of(input int s);
        return 32'h1000 + 32'(s * 16);
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input int s, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = 4'(s); wr_desc = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start(input logic [15:0] s);
        @(negedge clk);
        start = 1'b1; start_link = s;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Called one negedge after a go; drops done after one cycle.
    task automatic pulse_done();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic run_row(input logic [39:0] row);
        logic [15:0] s;
        int n;
        logic [7:0] fl;
        s  = row[39:24];
        n  = int'(row[23:20]);
        fl = row[7:0];
        pulse_start(s);
        for (int i = 0; i < n; i++) begin
            logic [3:0] slot;
            slot = row[19 - 4*i -: 4];
            chk("R4 go on load", 64'(eng_go), 64'd1);
            chk("R5 slot order", 64'(act_slot), 64'(slot));
            chk("R3 active source", 64'(act_desc[216:185]), 64'(src_of(int'(slot))));
            if (i == 0) chk("R9 flags cleared on start", {55'd0, all_done, wait_flags}, 64'd0);
            @(negedge clk);
            chk("R4 go single cycle", 64'(eng_go), 64'd0);
            pulse_done();
        end
        if (n == 0) chk("R6 null start no go", 64'(eng_go), 64'd0);
        chk("R7 idle at end", 64'(busy), 64'd0);
        chk("R7 all_done at end", 64'(all_done), 64'd1);
        chk("R8 wait flags", 64'(wait_flags), 64'(fl));
        repeat (3) @(negedge clk);
        chk("R9 flags sticky", {55'd0, all_done, wait_flags}, {55'd0, 1'b1, fl});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {52'd0, busy, eng_go, all_done, wait_flags}, 64'd0);

        // R2 program table
        wr(0, mk(src_of(0), 16'h100, 16'd1,     8'hFF, 1'b0));
        wr(1, mk(src_of(1), 16'h101, 16'd2,     8'd3,  1'b0));
        wr(2, mk(src_of(2), 16'h102, 16'hFFFF,  8'd5,  1'b0));
        wr(3, mk(src_of(3), 16'h103, 16'd4,     8'd2,  1'b1));
        wr(4, mk(src_of(4), 16'h104, 16'd5,     8'd0,  1'b0));
        wr(5, mk(src_of(5), 16'h105, 16'd20,    8'd7,  1'b0));
        wr(6, mk(src_of(6), 16'h106, 16'd7,     8'd9,  1'b0));
        wr(7, mk(src_of(7), 16'h107, 16'hFFFF,  8'd1,  1'b0));
        wr(8, mk(src_of(8), 16'h108, 16'd9,     8'd1,  1'b0));
        wr(9, mk(src_of(9), 16'h109, 16'd8,     8'd2,  1'b0));

        // R3 verbatim copy, including reload and link fields
        pulse_start(16'd1);
        chk("R3 busy after start", 64'(busy), 64'd1);
        chk("R3 full descriptor low", act_desc[63:0], 64'(mk(src_of(1), 16'h101, 16'd2, 8'd3, 1'b0)));
        chk("R2 reload field", 64'(act_desc[40:25]), 64'h101);
        chk("R2 destination field", 64'(act_desc[184:153]), 64'(32'hD000_0000 + src_of(1)));
        @(negedge clk);
        pulse_done();
        @(negedge clk);
        pulse_done();

        // Table of chains: R5 R6 R7 R8 R9
        for (int r = 0; r < 6; r++) run_row(ROWS[r]);

        // R10 start while busy
        pulse_start(16'd0);
        chk("R10 first slot", 64'(act_slot), 64'd0);
        pulse_start(16'd6);
        chk("R10 slot kept", 64'(act_slot), 64'd0);
        chk("R10 no new go", 64'(eng_go), 64'd0);
        chk("R10 still busy", 64'(busy), 64'd1);
        pulse_done();
        chk("R10 chain continues", 64'(act_slot), 64'd1);
        @(negedge clk);
        pulse_done();
        chk("R10 chain continues 2", 64'(act_slot), 64'd2);
        @(negedge clk);
        pulse_done();
        chk("R10 chain end flags", {55'd0, all_done, wait_flags}, {55'd0, 1'b1, 8'h29});

        // R5 ping-pong loop
        pulse_start(16'd8);
        for (int i = 0; i < 4; i++) begin
            chk("R5 ping-pong slot", 64'(act_slot), (i % 2 == 0) ? 64'd8 : 64'd9);
            chk("R5 ping-pong go", 64'(eng_go), 64'd1);
            @(negedge clk);
            pulse_done();
        end
        chk("R5 loop returns to 8", 64'(act_slot), 64'd8);
        chk("R8 flags mid loop", {55'd0, all_done, wait_flags}, {55'd0, 1'b0, 8'h06});
        // R11 rewrite active slot and make the partner final
        wr(8, mk(32'hAAAA_0000, 16'h1F8, 16'd9, 8'd1, 1'b0));
        wr(9, mk(src_of(9), 16'h109, 16'd8, 8'd2, 1'b1));
        chk("R11 active copy unchanged", 64'(act_desc[216:185]), 64'(src_of(8)));
        pulse_done();
        chk("R2 final bit written", 64'(act_desc[0]), 64'd1);
        chk("R5 partner loaded", 64'(act_slot), 64'd9);
        @(negedge clk);
        pulse_done();
        chk("R7 final ends loop", {54'd0, busy, all_done, wait_flags}, {54'd0, 1'b0, 1'b1, 8'h07});
        pulse_start(16'd8);
        chk("R11 new contents on reload", 64'(act_desc[216:185]), 64'h0000_0000_AAAA_0000);
        chk("R9 restart clears", {55'd0, all_done, wait_flags}, 64'd0);
        @(negedge clk);
        pulse_done();
        @(negedge clk);
        pulse_done();
        chk("R7 second loop end", {55'd0, all_done, wait_flags}, {55'd0, 1'b1, 8'h07});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule